// File: doc/BRIEF.md
# Dual-Mode FIFO Trigger-Level Controller

This block holds the receive and transmit byte queues of a serial port and works out when each queue has reached its interrupt trigger. It sizes both queues from register values. If the four extended level registers are all zero, each queue is 32 entries deep and the triggers come from fixed 2-bit codes. If any of those registers is nonzero, each queue is 128 entries deep and the triggers are taken directly from the extended transmit and receive level registers.

The receive flag reports that enough bytes are waiting to be read. The transmit flag reports that enough free room exists to write more. Any change of the effective size flushes both queues at once. Such a change is the enable bit going on or off, or the extended registers moving between all-zero and not-all-zero. The surrounding port logic feeds the block push and pop strobes together with byte data. It reads back the queue heads, the fill counts and the two flags.

Top module: `fifo_trig_ctrl`

## Requirements
- R1: With `fifo_en`=1 and all four extended registers zero, each queue holds at most 32 entries. A push while the count is 32 is dropped, the count stays 32 and that queue's overrun flag sets.
- R2: In the 32-entry mode, `rx_level_hit` is 1 exactly when `rx_count` is at least the level picked by `rx_code`: 0→8, 1→16, 2→24, 3→28.
- R3: In the 32-entry mode, `tx_level_hit` is 1 exactly when (32 − `tx_count`) is at least the level picked by the accepted transmit code: 0→16, 1→8, 2→24, 3→30. `tx_code` is accepted only in cycles with `enh_en`=1. Until then the previously accepted code stays in force, and after reset the accepted code is 0.
- R4: With `fifo_en`=1 and any extended register nonzero, each queue holds up to 128 entries.
- R5: In the 128-entry mode, `rx_level_hit` is 1 when `rx_count` ≥ L(`ext_rx_lvl`), and `tx_level_hit` is 1 when (128 − `tx_count`) ≥ L(`ext_tx_lvl`). L(0)=1, L(v)=v for 1..128, and L(v)=128 above 128.
- R6: Both queues are emptied in the clock edge that follows a change of `fifo_en`, or of the all-zero status of the extended registers. A push or pop in that cycle is discarded. A change of extended values that leaves them nonzero does not empty the queues.
- R7: With `fifo_en`=0, pushes and pops have no effect, both counts read 0 and both level flags read 0.
- R8: Bytes leave each queue in push order. `*_rdata` takes the popped byte at the clock edge that accepts the pop.
- R9: A pop while the count is 0 leaves the count at 0 and `*_rdata` unchanged.
- R10: An overrun flag stays set until reset, including across flushes. A push while full is dropped even when a pop is accepted in the same cycle, and that pop still removes one entry.
- R11: While `rst_n`=0 both counts, both overrun flags and both read-data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | Queue enable for both directions |
| enh_en | input | 1 | Enhanced-enable; allows a new transmit code to be accepted |
| rx_code | input | 2 | Receive trigger code for the 32-entry mode |
| tx_code | input | 2 | Transmit trigger code for the 32-entry mode |
| ext_tx_lvl | input | 8 | Extended transmit level register |
| ext_rx_lvl | input | 8 | Extended receive level register |
| ext_flow_hi | input | 8 | Extended flow high threshold register (used only for sizing) |
| ext_flow_lo | input | 8 | Extended flow low threshold register (used only for sizing) |
| rx_push | input | 1 | Write strobe, receive queue |
| rx_wdata | input | 8 | Byte to write, receive queue |
| rx_pop | input | 1 | Read strobe, receive queue |
| tx_push | input | 1 | Write strobe, transmit queue |
| tx_wdata | input | 8 | Byte to write, transmit queue |
| tx_pop | input | 1 | Read strobe, transmit queue |
| rx_rdata | output | 8 | Last byte popped from the receive queue |
| tx_rdata | output | 8 | Last byte popped from the transmit queue |
| rx_count | output | 8 | Receive fill count |
| tx_count | output | 8 | Transmit fill count |
| rx_level_hit | output | 1 | Receive trigger reached |
| tx_level_hit | output | 1 | Transmit free-room trigger reached |
| rx_overrun | output | 1 | Sticky receive overrun |
| tx_overrun | output | 1 | Sticky transmit overrun |

## Verification
Two events can land in the same cycle: a resize that triggers a flush, and a push or pop on a queue. The bench provokes this by clearing the extended registers, or by dropping the enable, on the very edge where it strobes a push into one queue and a pop from the other. It then expects both counts to read zero, with neither byte counted nor removed. A second collision is a push and a pop on a full queue. There the pop must go through and the push must be dropped, with the count falling by one and the overrun flag set.

// File: rtl/fifo_lvl_pkg.sv
package fifo_lvl_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_SMALL = 2'd1,
        MODE_LARGE = 2'd2
    } size_mode_e;

    // Fixed receive levels of the 32-entry mode
    function automatic int unsigned small_rx_level(input logic [1:0] code);
        case (code)
            2'd0:    return 8;
            2'd1:    return 16;
            2'd2:    return 24;
            default: return 28;
        endcase
    endfunction

    // Fixed transmit (free room) levels of the 32-entry mode
    function automatic int unsigned small_tx_level(input logic [1:0] code);
        case (code)
            2'd0:    return 16;
            2'd1:    return 8;
            2'd2:    return 24;
            default: return 30;
        endcase
    endfunction

endpackage

// File: rtl/fifo_lvl_mode.sv
module fifo_lvl_mode
    import fifo_lvl_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int SMALL_DEPTH = 32,
    parameter int LARGE_DEPTH = 128,
    parameter int CNT_W       = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_en,
    input  logic               enh_en,
    input  logic [1:0]         rx_code,
    input  logic [1:0]         tx_code,
    input  logic [REG_W-1:0]   ext_tx_lvl,
    input  logic [REG_W-1:0]   ext_rx_lvl,
    input  logic [REG_W-1:0]   ext_flow_hi,
    input  logic [REG_W-1:0]   ext_flow_lo,
    output size_mode_e         mode,
    output logic               flush,
    output logic [CNT_W-1:0]   depth,
    output logic [CNT_W-1:0]   rx_trig,
    output logic [CNT_W-1:0]   tx_trig
);

    typedef struct packed {
        size_mode_e mode;
        logic [1:0] tx_code;
    } mode_state_t;

    mode_state_t st_d, st_q;
    logic        ext_nz;

    function automatic logic [CNT_W-1:0] clamp_lvl(input logic [REG_W-1:0] v);
        if (v == '0)
            return CNT_W'(1);
        else if (32'(v) > LARGE_DEPTH)
            return CNT_W'(LARGE_DEPTH);
        else
            return CNT_W'(v);
    endfunction

    always_comb begin
        st_d   = st_q;
        ext_nz = |{ext_tx_lvl, ext_rx_lvl, ext_flow_hi, ext_flow_lo};
        if (!fifo_en)
            st_d.mode = MODE_OFF;
        else if (ext_nz)
            st_d.mode = MODE_LARGE;
        else
            st_d.mode = MODE_SMALL;
        if (enh_en)
            st_d.tx_code = tx_code;

        mode  = st_d.mode;
        flush = (st_d.mode != st_q.mode);

        case (st_d.mode)
            MODE_LARGE: begin
                depth   = CNT_W'(LARGE_DEPTH);
                rx_trig = clamp_lvl(ext_rx_lvl);
                tx_trig = clamp_lvl(ext_tx_lvl);
            end
            MODE_SMALL: begin
                depth   = CNT_W'(SMALL_DEPTH);
                rx_trig = CNT_W'(small_rx_level(rx_code));
                tx_trig = CNT_W'(small_tx_level(st_d.tx_code));
            end
            default: begin
                depth   = '0;
                rx_trig = '0;
                tx_trig = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode    <= MODE_OFF;
            st_q.tx_code <= 2'd0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fifo_lvl_buf.sv
module fifo_lvl_buf #(
    parameter int DATA_W      = 8,
    parameter int LARGE_DEPTH = 128,
    parameter int CNT_W       = 8,
    parameter int PTR_W       = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              flush,
    input  logic [CNT_W-1:0]  depth,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic              overrun
);

    typedef struct packed {
        logic [PTR_W-1:0]  wr_ptr;
        logic [PTR_W-1:0]  rd_ptr;
        logic [CNT_W-1:0]  count;
        logic [DATA_W-1:0] rdata;
        logic              ovr;
    } buf_state_t;

    buf_state_t        st_d, st_q;
    logic [DATA_W-1:0] mem [LARGE_DEPTH];
    logic              full, empty, live, do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                              input logic [CNT_W-1:0] d);
        if (CNT_W'(p) == d - CNT_W'(1))
            return '0;
        else
            return p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        live    = enable && !flush;
        full    = (st_q.count >= depth);
        empty   = (st_q.count == '0);
        do_push = live && push && !full;
        do_pop  = live && pop && !empty;

        if (live && push && full)
            st_d.ovr = 1'b1;

        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.count  = '0;
        end else begin
            if (do_push)
                st_d.wr_ptr = bump(st_q.wr_ptr, depth);
            if (do_pop) begin
                st_d.rd_ptr = bump(st_q.rd_ptr, depth);
                st_d.rdata  = mem[st_q.rd_ptr];
            end
            case ({do_push, do_pop})
                2'b10:   st_d.count = st_q.count + CNT_W'(1);
                2'b01:   st_d.count = st_q.count - CNT_W'(1);
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push)
            mem[st_q.wr_ptr] <= wdata;
    end

    assign rdata   = st_q.rdata;
    assign count   = st_q.count;
    assign overrun = st_q.ovr;

endmodule

// File: rtl/fifo_trig_ctrl.sv
module fifo_trig_ctrl
    import fifo_lvl_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int REG_W       = 8,
    parameter int SMALL_DEPTH = 32,
    parameter int LARGE_DEPTH = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              enh_en,
    input  logic [1:0]        rx_code,
    input  logic [1:0]        tx_code,
    input  logic [REG_W-1:0]  ext_tx_lvl,
    input  logic [REG_W-1:0]  ext_rx_lvl,
    input  logic [REG_W-1:0]  ext_flow_hi,
    input  logic [REG_W-1:0]  ext_flow_lo,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_pop,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    output logic [DATA_W-1:0] tx_rdata,
    output logic [$clog2(LARGE_DEPTH+1)-1:0] rx_count,
    output logic [$clog2(LARGE_DEPTH+1)-1:0] tx_count,
    output logic              rx_level_hit,
    output logic              tx_level_hit,
    output logic              rx_overrun,
    output logic              tx_overrun
);

    localparam int CNT_W = $clog2(LARGE_DEPTH + 1);
    localparam int PTR_W = $clog2(LARGE_DEPTH);

    size_mode_e       mode;
    logic             flush, active;
    logic [CNT_W-1:0] depth, rx_trig, tx_trig, tx_free;

    fifo_lvl_mode #(
        .REG_W(REG_W), .SMALL_DEPTH(SMALL_DEPTH),
        .LARGE_DEPTH(LARGE_DEPTH), .CNT_W(CNT_W)
    ) u_mode (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .enh_en(enh_en),
        .rx_code(rx_code), .tx_code(tx_code),
        .ext_tx_lvl(ext_tx_lvl), .ext_rx_lvl(ext_rx_lvl),
        .ext_flow_hi(ext_flow_hi), .ext_flow_lo(ext_flow_lo),
        .mode(mode), .flush(flush), .depth(depth),
        .rx_trig(rx_trig), .tx_trig(tx_trig)
    );

    assign active = (mode != MODE_OFF);

    fifo_lvl_buf #(
        .DATA_W(DATA_W), .LARGE_DEPTH(LARGE_DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)
    ) u_rx_buf (
        .clk(clk), .rst_n(rst_n), .enable(active), .flush(flush), .depth(depth),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
        .rdata(rx_rdata), .count(rx_count), .overrun(rx_overrun)
    );

    fifo_lvl_buf #(
        .DATA_W(DATA_W), .LARGE_DEPTH(LARGE_DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)
    ) u_tx_buf (
        .clk(clk), .rst_n(rst_n), .enable(active), .flush(flush), .depth(depth),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
        .rdata(tx_rdata), .count(tx_count), .overrun(tx_overrun)
    );

    always_comb begin
        tx_free      = depth - tx_count;
        rx_level_hit = active && (rx_count >= rx_trig);
        tx_level_hit = active && (tx_free >= tx_trig);
    end

endmodule

// File: rtl/fifo_trig_ctrl_chk.sv
module fifo_trig_ctrl_chk #(
    parameter int DATA_W      = 8,
    parameter int REG_W       = 8,
    parameter int SMALL_DEPTH = 32,
    parameter int LARGE_DEPTH = 128,
    parameter int CNT_W       = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_en,
    input logic [REG_W-1:0]  ext_tx_lvl,
    input logic [REG_W-1:0]  ext_rx_lvl,
    input logic [REG_W-1:0]  ext_flow_hi,
    input logic [REG_W-1:0]  ext_flow_lo,
    input logic              rx_push,
    input logic              rx_pop,
    input logic [DATA_W-1:0] rx_rdata,
    input logic [CNT_W-1:0]  rx_count,
    input logic [CNT_W-1:0]  tx_count,
    input logic              rx_level_hit,
    input logic              tx_level_hit,
    input logic              rx_overrun,
    input logic              tx_overrun
);

    logic       ext_nz, chg;
    logic [1:0] cfg_now, cfg_prev;

    assign ext_nz  = |{ext_tx_lvl, ext_rx_lvl, ext_flow_hi, ext_flow_lo};
    assign cfg_now = {fifo_en, fifo_en & ext_nz};
    assign chg     = (cfg_now != cfg_prev);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_prev <= 2'b00;
        else
            cfg_prev <= cfg_now;
    end

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (rx_count == '0) && (tx_count == '0)); // R6

    AST_SMALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg && fifo_en && !ext_nz) |-> (32'(rx_count) <= SMALL_DEPTH) && (32'(tx_count) <= SMALL_DEPTH)); // R1

    AST_LARGE_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg && fifo_en && ext_nz && 32'(rx_count) == SMALL_DEPTH && rx_push && !rx_pop)
        |=> (32'(rx_count) == SMALL_DEPTH + 1)); // R4

    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg && rx_count == '0 && rx_pop && !rx_push) |=> $stable(rx_rdata) && (rx_count == '0)); // R9

    AST_OVR_STICKY_RX: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> rx_overrun); // R10

    AST_OVR_STICKY_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_overrun |=> tx_overrun); // R10

    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !cfg_prev[1]) |-> (rx_count == '0) && (tx_count == '0)
                                        && !rx_level_hit && !tx_level_hit); // R7

endmodule

bind fifo_trig_ctrl fifo_trig_ctrl_chk #(
    .DATA_W(DATA_W), .REG_W(REG_W), .SMALL_DEPTH(SMALL_DEPTH),
    .LARGE_DEPTH(LARGE_DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .ext_tx_lvl(ext_tx_lvl), .ext_rx_lvl(ext_rx_lvl),
    .ext_flow_hi(ext_flow_hi), .ext_flow_lo(ext_flow_lo),
    .rx_push(rx_push), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .rx_count(rx_count), .tx_count(tx_count),
    .rx_level_hit(rx_level_hit), .tx_level_hit(tx_level_hit),
    .rx_overrun(rx_overrun), .tx_overrun(tx_overrun)
);

// File: tb/tb_fifo_trig_ctrl.sv
module tb_fifo_trig_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n, fifo_en, enh_en;
    logic [1:0] rx_code, tx_code;
    logic [7:0] ext_tx_lvl, ext_rx_lvl, ext_flow_hi, ext_flow_lo;
    logic       rx_push, rx_pop, tx_push, tx_pop;
    logic [7:0] rx_wdata, tx_wdata, rx_rdata, tx_rdata, rx_count, tx_count;
    logic       rx_level_hit, tx_level_hit, rx_overrun, tx_overrun;

    int checks = 0;
    int errors = 0;
    int next_val = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_trig_ctrl dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .enh_en(enh_en),
        .rx_code(rx_code), .tx_code(tx_code),
        .ext_tx_lvl(ext_tx_lvl), .ext_rx_lvl(ext_rx_lvl),
        .ext_flow_hi(ext_flow_hi), .ext_flow_lo(ext_flow_lo),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
        .rx_rdata(rx_rdata), .tx_rdata(tx_rdata),
        .rx_count(rx_count), .tx_count(tx_count),
        .rx_level_hit(rx_level_hit), .tx_level_hit(tx_level_hit),
        .rx_overrun(rx_overrun), .tx_overrun(tx_overrun)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rx_fill(input int n);
        for (int i = 0; i < n; i++) begin
            rx_push = 1'b1; rx_wdata = 8'(next_val); next_val++;
            step(1);
        end
        rx_push = 1'b0;
    endtask

    task automatic tx_fill(input int n);
        for (int i = 0; i < n; i++) begin
            tx_push = 1'b1; tx_wdata = 8'(i);
            step(1);
        end
        tx_push = 1'b0;
    endtask

    task automatic tx_drain(input int n);
        tx_pop = 1'b1; step(n); tx_pop = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; fifo_en = 1'b0; enh_en = 1'b0;
        rx_code = 2'd0; tx_code = 2'd0;
        ext_tx_lvl = '0; ext_rx_lvl = '0; ext_flow_hi = '0; ext_flow_lo = '0;
        rx_push = 1'b0; rx_pop = 1'b0; tx_push = 1'b0; tx_pop = 1'b0;
        rx_wdata = '0; tx_wdata = '0;
        step(3);
        chk("R11 rx_count", int'(rx_count), 0);
        chk("R11 tx_count", int'(tx_count), 0);
        chk("R11 overruns", int'({rx_overrun, tx_overrun}), 0);
        chk("R11 rdata", int'({rx_rdata, tx_rdata}), 0);
        rst_n = 1'b1;
        step(2);
        chk("R7 flags when disabled", int'({rx_level_hit, tx_level_hit}), 0);
    endtask

    task automatic t_rx_small;
        fifo_en = 1'b1; step(2);
        chk("R6 empty after enable", int'(rx_count), 0);
        rx_code = 2'd0; rx_fill(7);
        chk("R2 code0 at 7", int'(rx_level_hit), 0);
        rx_fill(1);
        chk("R2 code0 at 8", int'(rx_level_hit), 1);
        rx_code = 2'd1; step(1);
        chk("R2 code1 at 8", int'(rx_level_hit), 0);
        rx_fill(8);
        chk("R2 code1 at 16", int'(rx_level_hit), 1);
        rx_code = 2'd2; step(1);
        chk("R2 code2 at 16", int'(rx_level_hit), 0);
        rx_fill(8);
        chk("R2 code2 at 24", int'(rx_level_hit), 1);
        rx_code = 2'd3; step(1);
        chk("R2 code3 at 24", int'(rx_level_hit), 0);
        rx_fill(3);
        chk("R2 code3 at 27", int'(rx_level_hit), 0);
        rx_fill(1);
        chk("R2 code3 at 28", int'(rx_level_hit), 1);
        rx_fill(4);
        chk("R1 count at 32", int'(rx_count), 32);
        chk("R1 no overrun yet", int'(rx_overrun), 0);
        rx_fill(1);
        chk("R1 count stays 32", int'(rx_count), 32);
        chk("R1 overrun set", int'(rx_overrun), 1);
        for (int i = 0; i < 32; i++) begin
            rx_pop = 1'b1; step(1);
            chk("R8 pop order", int'(rx_rdata), i);
        end
        rx_pop = 1'b0;
        chk("R8 drained", int'(rx_count), 0);
        rx_pop = 1'b1; step(1); rx_pop = 1'b0;
        chk("R9 rdata kept", int'(rx_rdata), 31);
        chk("R9 count kept", int'(rx_count), 0);
    endtask

    task automatic t_tx_small;
        chk("R3 reset code, free 32", int'(tx_level_hit), 1);
        tx_fill(16);
        chk("R3 free 16 code0", int'(tx_level_hit), 1);
        tx_fill(1);
        chk("R3 free 15 code0", int'(tx_level_hit), 0);
        tx_code = 2'd1; step(1);
        chk("R3 code held without enh", int'(tx_level_hit), 0);
        enh_en = 1'b1; step(1);
        chk("R3 code1 accepted", int'(tx_level_hit), 1);
        enh_en = 1'b0; tx_code = 2'd2; step(1);
        chk("R3 code1 still in force", int'(tx_level_hit), 1);
        enh_en = 1'b1; step(1);
        chk("R3 code2 free 15", int'(tx_level_hit), 0);
        tx_code = 2'd3; tx_drain(15);
        chk("R3 code3 free 30", int'(tx_level_hit), 1);
        tx_fill(1);
        chk("R3 code3 free 29", int'(tx_level_hit), 0);
        chk("R3 tx_count", int'(tx_count), 3);
    endtask

    task automatic t_ext;
        rx_fill(3);
        ext_flow_lo = 8'd1; step(2);
        chk("R6 rx flushed on resize", int'(rx_count), 0);
        chk("R6 tx flushed on resize", int'(tx_count), 0);
        chk("R5 rx level 0 acts as 1, count 0", int'(rx_level_hit), 0);
        rx_fill(1);
        chk("R5 rx level 0 acts as 1, count 1", int'(rx_level_hit), 1);
        ext_rx_lvl = 8'd50; rx_fill(48);
        chk("R5 rx 49 of 50", int'(rx_level_hit), 0);
        rx_fill(1);
        chk("R5 rx 50 of 50", int'(rx_level_hit), 1);
        ext_flow_hi = 8'd5; step(1);
        chk("R6 no flush while nonzero", int'(rx_count), 50);
        ext_rx_lvl = 8'd200; rx_fill(77);
        chk("R5 clamp 128, count 127", int'(rx_level_hit), 0);
        rx_fill(1);
        chk("R5 clamp 128, count 128", int'(rx_level_hit), 1);
        chk("R4 count 128", int'(rx_count), 128);
        rx_fill(1);
        chk("R4 stop at 128", int'(rx_count), 128);
        ext_tx_lvl = 8'd100; step(1);
        chk("R5 tx free 128", int'(tx_level_hit), 1);
        tx_fill(28);
        chk("R5 tx free 100", int'(tx_level_hit), 1);
        tx_fill(1);
        chk("R5 tx free 99", int'(tx_level_hit), 0);
        chk("R4 no tx overrun", int'(tx_overrun), 0);
    endtask

    task automatic t_collide;
        ext_tx_lvl = '0; ext_rx_lvl = '0; ext_flow_hi = '0; ext_flow_lo = '0;
        rx_push = 1'b1; rx_wdata = 8'hAA; tx_pop = 1'b1;
        step(1);
        rx_push = 1'b0; tx_pop = 1'b0;
        chk("R6 rx push dropped at flush", int'(rx_count), 0);
        chk("R6 tx pop dropped at flush", int'(tx_count), 0);
        tx_fill(32);
        tx_push = 1'b1; tx_pop = 1'b1; step(1);
        tx_push = 1'b0; tx_pop = 1'b0;
        chk("R10 pop taken when full", int'(tx_count), 31);
        chk("R10 push dropped when full", int'(tx_overrun), 1);
        chk("R8 tx head", int'(tx_rdata), 0);
        fifo_en = 1'b0; tx_push = 1'b1; step(1); tx_push = 1'b0;
        chk("R6 flush on disable", int'(tx_count), 0);
        chk("R10 overrun survives flush", int'(tx_overrun), 1);
        rx_push = 1'b1; tx_push = 1'b1; step(2);
        rx_push = 1'b0; tx_push = 1'b0;
        chk("R7 rx push ignored", int'(rx_count), 0);
        chk("R7 tx push ignored", int'(tx_count), 0);
        chk("R7 flags low", int'({rx_level_hit, tx_level_hit}), 0);
    endtask

    initial begin
        t_reset;
        t_rx_small;
        t_tx_small;
        t_ext;
        t_collide;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule